// File: doc/BRIEF.md
# Flux-pulse PWM symbol decoder

This block sits behind a floppy drive's read-data output when the disk carries pulse-width-modulated symbols instead of the usual bit-cell encoding. Each recorded flux reversal reaches the block as the same active-low pulse, whichever way the medium flipped. The block therefore has no direct way to tell a pulse that opens a symbol cycle from a pulse that marks the symbol's duty edge. It settles this by timing. It measures the gap between accepted pulses in clock ticks, with one tick standing for 62.5 ns of disk time. It treats even-numbered and odd-numbered pulses as two rival phase hypotheses, and it adopts the one whose pulses recur at the nominal symbol period.

Once it has locked, every duty pulse becomes a 4-bit value. One reserved value is reported as a frame-sync strobe instead of a data nibble. A toggle output rebuilds the recorded pulse-width waveform so that it can drive an audio stage directly. While locked, that output is forced high at every confirmed cycle start, so its polarity is correct. A falling edge on the index input throws the decoder back into phase search, so the header that follows the index can be used to lock again.

The controller has two states. In SEARCH it hunts for phase. In TRACK it decodes symbols. Three transitions connect them:
- LOCK_ACQUIRE takes SEARCH to TRACK when the run of good periods reaches its target.
- MISS_DROP takes TRACK to SEARCH on too many consecutive bad start periods.
- INDEX_RESTART takes TRACK to SEARCH on an index edge. In SEARCH, an index edge only clears the runs.

Top module: `flux_pwm_decoder`

## Requirements
- R1: After reset, `nib_valid`, `frame_sync`, `pwm_out` and `locked` are all low, and the state is SEARCH.
- R2: A falling edge on `rd_n` that comes less than 16 clocks after the last accepted pulse is discarded. It does not toggle `pwm_out`, it does not count as a pulse, and it does not move the timing reference.
- R3: Accepted pulses alternate between parity 0 and parity 1. In SEARCH, each parity keeps its own count of consecutive pulses whose spacing from the pulse two before them lies in 78..82 clocks. When a count reaches 8, LOCK_ACQUIRE fires. That parity becomes the start parity, and `locked` goes high.
- R4: While `locked` is low, neither `nib_valid` nor `frame_sync` is ever asserted.
- R5: In TRACK, a pulse of the non-start parity yields the value (clocks since the start pulse − 32), clamped to the range 0..15. Any value other than 15 is presented on `nib_data` with a one-cycle `nib_valid`.
- R6: The value 15 is reserved for vertical sync. It produces a one-cycle `frame_sync` and no `nib_valid`. Gaps below 32 clocks decode as 0, and gaps of 47 clocks or more decode as 15.
- R7: In TRACK, each start pulse whose period falls outside 78..82 adds one miss, and a good period clears the misses. On the third consecutive miss, MISS_DROP returns the block to SEARCH with both runs cleared. Duty pulses after the first two bad starts are still decoded, but the duty pulse after the third is not.
- R8: A falling edge on `index_n` forces SEARCH and clears both runs. A duty pulse that arrives in the same cycle as the index edge produces no strobe.
- R9: `pwm_out` toggles on every accepted pulse, except that it is set to 1 on LOCK_ACQUIRE and at every in-range start pulse in TRACK. As a result, it is low whenever a strobe is presented.
- R10: `nib_valid` and `frame_sync` are never high together, and each lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; one tick is the timing quantum |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_n | input | 1 | Asynchronous active-low read pulse, one per flux reversal |
| index_n | input | 1 | Asynchronous active-low once-per-revolution index |
| nib_data | output | 4 | Decoded symbol value |
| nib_valid | output | 1 | One-cycle strobe for `nib_data` |
| frame_sync | output | 1 | One-cycle strobe for the reserved sync symbol |
| pwm_out | output | 1 | Rebuilt pulse-width waveform |
| locked | output | 1 | High while in TRACK |

## Verification
An index edge and a read pulse can reach the control logic in the same cycle, because both pass through synchronizers of equal depth. The bench provokes this by pulling `index_n` and `rd_n` low on the same clock while the decoder is locked and a duty pulse is due. It judges the outcome as follows: no strobe may appear for that symbol, `locked` must be low afterwards, and decoded output may return only after eight fresh in-range start periods. A second overlap, a start pulse being both the third miss and the boundary of the next duty measurement, is judged by the symbol whose nibble must vanish while the previous two still decode.

// File: rtl/flux_pkg.sv
package flux_pkg;
    typedef enum logic {
        ST_SEARCH = 1'b0,
        ST_TRACK  = 1'b1
    } trk_state_t;
endpackage

// File: rtl/flux_edge_sync.sv
module flux_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din_n,
    output logic fall
);
    logic [2:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shreg <= '1;
        else        shreg <= {shreg[1:0], din_n};
    end

    // High for one cycle after the synchronized input has gone low
    assign fall = shreg[2] & ~shreg[1];
endmodule

// File: rtl/flux_interval.sv
module flux_interval #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit,
    output logic [CW-1:0] since_last,
    output logic [CW-1:0] since_prev2
);
    localparam logic [CW-1:0] SAT = '1;

    function automatic logic [CW-1:0] inc_sat(input logic [CW-1:0] v);
        return (v == SAT) ? SAT : v + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_last  <= SAT;
            since_prev2 <= SAT;
        end else if (hit) begin
            since_last  <= CW'(1);
            since_prev2 <= inc_sat(since_last);
        end else begin
            since_last  <= inc_sat(since_last);
            since_prev2 <= inc_sat(since_prev2);
        end
    end
endmodule

// File: rtl/flux_slicer.sv
module flux_slicer #(
    parameter int CW     = 8,
    parameter int NW     = 4,
    parameter int OFFSET = 32
) (
    input  logic [CW-1:0] gap,
    output logic [NW-1:0] value
);
    localparam int MAXV = (1 << NW) - 1;
    logic [CW-1:0] diff;

    always_comb begin
        diff = gap - CW'(OFFSET);
        if (gap < CW'(OFFSET))    value = '0;
        else if (diff > CW'(MAXV)) value = NW'(MAXV);
        else                       value = diff[NW-1:0];
    end
endmodule

// File: rtl/flux_pwm_decoder.sv
module flux_pwm_decoder
    import flux_pkg::*;
#(
    parameter int PERIOD    = 80,
    parameter int TOL       = 2,
    parameter int LOCK_RUN  = 8,
    parameter int DROP_MISS = 3,
    parameter int OFFSET    = 32,
    parameter int GUARD     = 16,
    parameter int NW        = 4,
    parameter int CW        = 8,
    parameter int SYNC_CODE = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_n,
    input  logic          index_n,
    output logic [NW-1:0] nib_data,
    output logic          nib_valid,
    output logic          frame_sync,
    output logic          pwm_out,
    output logic          locked
);
    localparam int LO = PERIOD - TOL;
    localparam int HI = PERIOD + TOL;
    localparam int RW = $clog2(LOCK_RUN + 1);
    localparam int MW = $clog2(DROP_MISS + 1);

    trk_state_t state, state_n;

    logic          rd_fall, idx_fall, accept, period_ok;
    logic [CW-1:0] since_last, since_prev2;
    logic [NW-1:0] slice;
    logic          par, start_par;
    logic [RW-1:0] run_q [2];
    logic [MW-1:0] miss_q;
    logic          lock_evt, drop_evt, is_start, is_duty;

    flux_edge_sync u_rd_sync  (.clk(clk), .rst_n(rst_n), .din_n(rd_n),    .fall(rd_fall));
    flux_edge_sync u_idx_sync (.clk(clk), .rst_n(rst_n), .din_n(index_n), .fall(idx_fall));

    flux_interval #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .hit(accept),
        .since_last(since_last), .since_prev2(since_prev2)
    );

    flux_slicer #(.CW(CW), .NW(NW), .OFFSET(OFFSET)) u_slicer (
        .gap(since_last), .value(slice)
    );

    assign accept    = rd_fall && (since_last >= CW'(GUARD));
    assign period_ok = (since_prev2 >= CW'(LO)) && (since_prev2 <= CW'(HI));
    assign is_start  = accept && (par == start_par);
    assign is_duty   = accept && (par != start_par) && (state == ST_TRACK) && !idx_fall;
    assign locked    = (state == ST_TRACK);

    // Next-state logic
    always_comb begin
        state_n  = state;
        lock_evt = 1'b0;
        drop_evt = 1'b0;
        unique case (state)
            ST_SEARCH: begin
                if (!idx_fall && accept && period_ok && run_q[par] == RW'(LOCK_RUN - 1)) begin
                    state_n  = ST_TRACK;   // LOCK_ACQUIRE
                    lock_evt = 1'b1;
                end
            end
            ST_TRACK: begin
                if (idx_fall) begin
                    state_n = ST_SEARCH;   // INDEX_RESTART
                end else if (is_start && !period_ok && miss_q == MW'(DROP_MISS - 1)) begin
                    state_n  = ST_SEARCH;  // MISS_DROP
                    drop_evt = 1'b1;
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_SEARCH;
        else        state <= state_n;
    end

    // Phase search bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            par       <= 1'b0;
            start_par <= 1'b0;
            run_q[0]  <= '0;
            run_q[1]  <= '0;
            miss_q    <= '0;
        end else begin
            if (accept) par <= ~par;
            if (idx_fall || drop_evt || lock_evt) begin
                run_q[0] <= '0;
                run_q[1] <= '0;
                miss_q   <= '0;
                if (lock_evt) start_par <= par;
            end else if (state == ST_SEARCH && accept) begin
                run_q[par] <= period_ok ? run_q[par] + 1'b1 : '0;
            end else if (state == ST_TRACK && is_start) begin
                miss_q <= period_ok ? '0 : miss_q + 1'b1;
            end
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nib_data   <= '0;
            nib_valid  <= 1'b0;
            frame_sync <= 1'b0;
            pwm_out    <= 1'b0;
        end else begin
            nib_valid  <= 1'b0;
            frame_sync <= 1'b0;
            if (lock_evt)
                pwm_out <= 1'b1;
            else if (state == ST_TRACK && is_start && period_ok && !idx_fall)
                pwm_out <= 1'b1;
            else if (accept)
                pwm_out <= ~pwm_out;
            if (is_duty) begin
                if (slice == NW'(SYNC_CODE)) begin
                    frame_sync <= 1'b1;
                end else begin
                    nib_valid <= 1'b1;
                    nib_data  <= slice;
                end
            end
        end
    end
endmodule

// File: rtl/flux_pwm_decoder_chk.sv
module flux_pwm_decoder_chk #(
    parameter int NW        = 4,
    parameter int SYNC_CODE = 15
) (
    input logic          clk,
    input logic          rst_n,
    input logic          idx_fall,
    input logic [NW-1:0] nib_data,
    input logic          nib_valid,
    input logic          frame_sync,
    input logic          pwm_out,
    input logic          locked
);
    AST_QUIET_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (nib_valid || frame_sync) |-> locked);                          // R4
    AST_NO_SYNC_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        nib_valid |-> (nib_data != NW'(SYNC_CODE)));                    // R6
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(nib_valid && frame_sync));                                    // R10
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (nib_valid || frame_sync) |=> !(nib_valid || frame_sync));      // R10
    AST_INDEX_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        idx_fall |=> !locked);                                          // R8
    AST_LOCK_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> pwm_out);                                     // R9
    AST_STROBE_PWM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (nib_valid || frame_sync) |-> !pwm_out);                        // R9
endmodule

bind flux_pwm_decoder flux_pwm_decoder_chk #(.NW(NW), .SYNC_CODE(SYNC_CODE)) u_chk (
    .clk(clk), .rst_n(rst_n), .idx_fall(idx_fall),
    .nib_data(nib_data), .nib_valid(nib_valid), .frame_sync(frame_sync),
    .pwm_out(pwm_out), .locked(locked)
);

// File: tb/tb_flux_pwm_decoder.sv
module tb_flux_pwm_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_n = 1'b1;
    logic       index_n = 1'b1;
    logic [3:0] nib_data;
    logic       nib_valid, frame_sync, pwm_out, locked;

    int compared = 0;
    int mismatched = 0;
    int spent = 0;
    int last_duty = 40;
    int run_m = 0;
    int miss_m = 0;
    bit locked_m = 0;
    bit have_start = 0;
    bit done = 0;
    int exp_q [$];

    always #5 clk = ~clk;

    flux_pwm_decoder dut (
        .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .index_n(index_n),
        .nib_data(nib_data), .nib_valid(nib_valid), .frame_sync(frame_sync),
        .pwm_out(pwm_out), .locked(locked)
    );

    task automatic check(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One falling pulse, 'gap' clocks after the previous one
    task automatic flux(input int gap, input bit with_idx);
        repeat (gap - 2 - spent) @(negedge clk);
        spent = 0;
        rd_n = 1'b0;
        if (with_idx) index_n = 1'b0;
        repeat (2) @(negedge clk);
        rd_n = 1'b1;
        index_n = 1'b1;
    endtask

    task automatic index_pulse();
        @(negedge clk); index_n = 1'b0;
        @(negedge clk);
        @(negedge clk); index_n = 1'b1;
        spent += 3;
        run_m = 0; miss_m = 0; locked_m = 0;
    endtask

    // One symbol: start pulse, optional noise, duty pulse; pushes expected result
    task automatic send_sym(input int duty, input int extra, input bit noise, input bit idx);
        bit ok, emit;
        int v;
        flux(80 - last_duty + extra, 1'b0);
        ok = (extra >= -2) && (extra <= 2);
        if (locked_m) begin
            miss_m = ok ? 0 : miss_m + 1;
            if (miss_m == 3) begin locked_m = 0; run_m = 0; miss_m = 0; end
        end else begin
            run_m = (have_start && ok) ? run_m + 1 : 0;
            if (run_m == 8) begin locked_m = 1; run_m = 0; miss_m = 0; end
        end
        have_start = 1;
        emit = locked_m && !idx;
        if (idx) begin locked_m = 0; run_m = 0; miss_m = 0; end
        v = (duty < 32) ? 0 : ((duty - 32 > 15) ? 15 : duty - 32);
        if (emit) exp_q.push_back((v == 15) ? 16 : v);
        if (noise) begin
            flux(10, 1'b0);      // R2: too close, must be ignored
            flux(duty - 10, idx);
        end else begin
            flux(duty, idx);
        end
        last_duty = duty;
        @(negedge clk);
        spent = 1;
        check("R3 R7 R8 locked", locked, locked_m);
    endtask

    task automatic header(input int n);
        for (int i = 0; i < n; i++) send_sym((i % 2) ? 44 : 34, 0, 1'b0, 1'b0);
    endtask

    // Monitor: compares every strobe with the scoreboard
    always @(negedge clk) begin
        if (rst_n && (nib_valid || frame_sync)) begin
            int act;
            act = frame_sync ? 16 : int'(nib_data);
            if (exp_q.size() == 0) begin
                check("R4 unexpected strobe", act, -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                check("R5 R6 symbol", act, e);
            end
            check("R9 pwm low at strobe", pwm_out, 0);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1 nib_valid", nib_valid, 0);
        check("R1 frame_sync", frame_sync, 0);
        check("R1 pwm_out", pwm_out, 0);
        check("R1 locked", locked, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        header(9);                           // R3: lock on ninth start
        send_sym(40, 0, 1'b0, 1'b0);         // R5 value 8
        send_sym(33, 0, 1'b0, 1'b0);         // R5 value 1
        send_sym(32, 0, 1'b0, 1'b0);         // R5 value 0
        send_sym(30, 0, 1'b0, 1'b0);         // R6 clamp low
        send_sym(46, 0, 1'b0, 1'b0);         // R5 value 14
        send_sym(47, 0, 1'b0, 1'b0);         // R6 frame sync
        send_sym(55, 0, 1'b0, 1'b0);         // R6 clamp high to sync
        send_sym(41, 0, 1'b1, 1'b0);         // R2 noise ignored
        send_sym(36, 0, 1'b0, 1'b0);

        index_pulse();                       // R8 restart
        header(8);
        send_sym(38, 0, 1'b0, 1'b0);

        send_sym(40, 10, 1'b0, 1'b0);        // R7 miss 1
        send_sym(42, 10, 1'b0, 1'b0);        // R7 miss 2
        send_sym(43, 10, 1'b0, 1'b0);        // R7 miss 3, dropped
        header(8);
        send_sym(45, 0, 1'b0, 1'b0);

        send_sym(37, 0, 1'b0, 1'b1);         // R8 index with duty pulse
        header(8);
        send_sym(39, 0, 1'b0, 1'b0);

        repeat (20) @(negedge clk);
        check("R4 R10 leftover expected", exp_q.size(), 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule